// File: doc/BRIEF.md
# Level-1 Accept Readout Buffer

This block keeps the most recent pixel slices from five finder sources and sends one stored event out on a level-1 accept. Each source has its own ring of 24 slice positions of 32 bits: eight cells of three slices each, where slot = cell*3 + slice. A source stores a slice in every cycle its valid is high. When no accept arrives, new slices simply overwrite the oldest ones.

An accept freezes the bank that is being written and starts a drain. The frozen event goes out as 16-bit words, one per cycle. A 5-to-1 selection picks the source and a 2-to-1 selection picks the half of the slice. While the drain runs, the writers use the second bank, so the data being read is never overwritten. Accepts that arrive during a drain wait in a short queue. If that queue is full when another accept arrives, a sticky overflow flag is raised.

Top module: `l1a_readout_buf`

## Requirements
- R1: A source whose valid is high at a rising edge stores its 32-bit slice in the next slot of its own 24-slot ring, wrapping from slot 23 back to slot 0. A source whose valid is low stores nothing and does not advance.
- R2: Every source restarts at slot 0 on the edge that freezes an event. Slot s of a frozen event holds the last slice written to s since the previous freeze. A slice written on the freezing edge itself still belongs to the frozen event.
- R3: An event is sent as 240 words in this order: sources 0 to 4, within each source slots 0 to 23, and within each slot bits 31:16 before bits 15:0. `out_valid` stays high for all 240 words of the event with no gaps.
- R4: `out_last` is high together with the 240th word of an event and low at all other times.
- R5: An accept sampled while idle makes the first word appear at the second rising edge, counting the sampling edge as the first. `out_valid` is therefore low for one cycle after the accept.
- R6: Slices written while a drain is running go to the other bank. They do not change the event being sent, and they form the next event.
- R7: Accepts that arrive during a drain are held, up to two of them, and served one after another. Each event starts in the cycle right after the last word of the event before it. An accept that coincides with a last word takes a free place in the queue.
- R8: An accept that arrives during a drain while two accepts are already held, and that does not coincide with a last word, sets `overflow`. `overflow` then stays high until reset.
- R9: After a synchronous active-low reset, `out_valid`, `out_last` and `overflow` are low, the block is idle and every ring restarts at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| src_valid | input | 5 | Per-source slice write enable, bit s for source s |
| src_data | input | 160 | Per-source slice, bits s*32 +: 32 for source s |
| l1a | input | 1 | Level-1 accept strobe |
| out_data | output | 16 | Readout word |
| out_valid | output | 1 | Readout word is valid |
| out_last | output | 1 | Marks the final word of an event |
| overflow | output | 1 | Sticky: an accept was lost because the queue was full |

## Verification
The assertions check these properties on every cycle:
- the ring pointer stays in range, steps by one on each write and restarts when an event is frozen;
- the held-accept count never goes above two, and `overflow` never drops;
- the drain never stops before its last word, and the halves of each slice alternate;
- `out_valid` follows the readout enable by one cycle, and `out_last` never appears without `out_valid`.

Only the bench scenarios can show that the correct slices come out in the correct order. Those scenarios cover ring wrap after more than 24 writes, writes with gaps in valid, bank isolation while new data streams in during a drain, three accepts in a row that chain events and overflow the queue, and the exact position of each end marker.

// File: rtl/xrb_pkg.sv
// Package: shared geometry and controller state for the accept readout buffer.
// Assumes every module gets its sizes from these constants through parameters.
package xrb_pkg;
    localparam int NUM_SRC_D = 5;   // finder sources
    localparam int NUM_CELL_D = 8;  // cells per source
    localparam int NUM_SLC_D = 3;   // slices per cell
    localparam int SLICE_W_D = 32;  // bits per slice
    localparam int WORD_W_D = 16;   // bits per output word
    localparam int QDEPTH_D = 2;    // accepts held during a drain

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_DRAIN = 1'b1
    } rd_state_t;
endpackage

// File: rtl/xrb_slice_ring.sv
// Module: one source's double-banked ring of slice slots.
// Writes go to the live bank at a pointer that wraps over SLOTS positions;
// reads come combinationally from the frozen (non-live) bank.
// Assumes swap pulses for one cycle on the edge that freezes an event.
module xrb_slice_ring #(
    parameter int SLICE_W = 32,
    parameter int SLOTS   = 24,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SLICE_W-1:0] wr_data,
    input  logic               live_bank,
    input  logic               swap,
    input  logic [SLOT_W-1:0]  rd_slot,
    output logic [SLICE_W-1:0] rd_data
);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);

    logic [SLICE_W-1:0] mem_q [2][SLOTS];
    logic [SLOT_W-1:0]  wr_ptr_q;

    // Storage: the write lands in the bank that is live on this edge.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[live_bank][wr_ptr_q] <= wr_data;
        end
    end

    // Write pointer: restarts on freeze, otherwise steps and wraps per write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
        end else if (swap) begin
            wr_ptr_q <= '0;
        end else if (wr_en) begin
            wr_ptr_q <= (wr_ptr_q == SLOT_LAST) ? '0 : wr_ptr_q + 1'b1;
        end
    end

    // Read port: always the frozen bank.
    assign rd_data = mem_q[~live_bank][rd_slot];

    p_ptr_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ptr_q <= SLOT_LAST);
    p_ptr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !swap && wr_ptr_q != SLOT_LAST) |=> wr_ptr_q == $past(wr_ptr_q) + 1'b1);
    p_ptr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !swap) |=> $stable(wr_ptr_q));
    p_ptr_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        swap |=> wr_ptr_q == '0);
endmodule

// File: rtl/xrb_readout_ctrl.sv
// Module: accept handling and drain sequencer.
// Freezes a bank on an accept, steps a cursor over source, slot and half,
// holds up to QDEPTH accepts that arrive during a drain and chains them
// back to back, and raises a sticky overflow when the queue is full.
module xrb_readout_ctrl #(
    parameter int NUM_SRC = 5,
    parameter int SLOTS   = 24,
    parameter int PARTS   = 2,
    parameter int QDEPTH  = 2,
    localparam int SRC_W  = $clog2(NUM_SRC),
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int PART_W = (PARTS > 1) ? $clog2(PARTS) : 1,
    localparam int PEND_W = $clog2(QDEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l1a,
    output logic              rd_en,
    output logic              rd_last,
    output logic [SRC_W-1:0]  rd_src,
    output logic [SLOT_W-1:0] rd_slot,
    output logic [PART_W-1:0] rd_part,
    output logic              live_bank,
    output logic              swap,
    output logic              overflow
);
    import xrb_pkg::*;

    localparam logic [SRC_W-1:0]  SRC_LAST  = SRC_W'(NUM_SRC - 1);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);
    localparam logic [PART_W-1:0] PART_LAST = PART_W'(PARTS - 1);
    localparam logic [PEND_W-1:0] PEND_MAX  = PEND_W'(QDEPTH);

    rd_state_t         state_q, state_d;
    logic [SRC_W-1:0]  src_q;
    logic [SLOT_W-1:0] slot_q;
    logic [PART_W-1:0] part_q;
    logic [PEND_W-1:0] pend_q, pend_d;
    logic [PEND_W:0]   held_total;
    logic              ovf_q, ovf_d;
    logic              bank_q;
    logic              busy, at_last, acc_busy, start;

    assign busy    = (state_q == ST_DRAIN);
    assign at_last = busy && src_q == SRC_LAST && slot_q == SLOT_LAST && part_q == PART_LAST;

    // Next-state: start decision, queue count and overflow.
    always_comb begin
        acc_busy   = busy && l1a;
        held_total = {1'b0, pend_q} + {{PEND_W{1'b0}}, acc_busy};
        start      = (!busy && l1a) || (at_last && held_total != '0);
        pend_d     = pend_q;
        ovf_d      = ovf_q;
        if (at_last) begin
            if (held_total != '0) begin
                pend_d = PEND_W'(held_total - 1'b1);
            end
        end else if (acc_busy) begin
            if (pend_q < PEND_MAX) begin
                pend_d = pend_q + 1'b1;
            end else begin
                ovf_d = 1'b1;
            end
        end
        if (start) begin
            state_d = ST_DRAIN;
        end else if (at_last) begin
            state_d = ST_IDLE;
        end else begin
            state_d = state_q;
        end
    end

    // Control state: drain flag, queue, overflow and live bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
            ovf_q   <= 1'b0;
            bank_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
            ovf_q   <= ovf_d;
            if (start) begin
                bank_q <= ~bank_q;
            end
        end
    end

    // Cursor: half, then slot, then source; cleared when an event starts.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            src_q  <= '0;
            slot_q <= '0;
            part_q <= '0;
        end else if (busy) begin
            if (part_q == PART_LAST) begin
                part_q <= '0;
                if (slot_q == SLOT_LAST) begin
                    slot_q <= '0;
                    src_q  <= (src_q == SRC_LAST) ? '0 : src_q + 1'b1;
                end else begin
                    slot_q <= slot_q + 1'b1;
                end
            end else begin
                part_q <= part_q + 1'b1;
            end
        end
    end

    assign rd_en     = busy;
    assign rd_last   = at_last;
    assign rd_src    = src_q;
    assign rd_slot   = slot_q;
    assign rd_part   = part_q;
    assign live_bank = bank_q;
    assign swap      = start;
    assign overflow  = ovf_q;

    p_pend_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q <= PEND_MAX);
    p_chain_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (at_last && pend_q != '0) |=> busy && src_q == '0 && slot_q == '0 && part_q == '0);
    p_no_overflow_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> ovf_q);
    p_stream_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !at_last) |=> busy);
    p_part_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && part_q != PART_LAST) |=> part_q == $past(part_q) + 1'b1);
endmodule

// File: rtl/xrb_word_mux.sv
// Module: source select, half select and output register.
// Picks one source's frozen slice, then one WORD_W part of it, with the
// most significant part first, and registers it with valid and last.
module xrb_word_mux #(
    parameter int NUM_SRC = 5,
    parameter int SLICE_W = 32,
    parameter int WORD_W  = 16,
    localparam int PARTS  = SLICE_W / WORD_W,
    localparam int SRC_W  = $clog2(NUM_SRC),
    localparam int PART_W = (PARTS > 1) ? $clog2(PARTS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rd_en,
    input  logic                       rd_last,
    input  logic [SRC_W-1:0]           rd_src,
    input  logic [PART_W-1:0]          rd_part,
    input  logic [NUM_SRC*SLICE_W-1:0] slices,
    output logic [WORD_W-1:0]          out_data,
    output logic                       out_valid,
    output logic                       out_last
);
    logic [SLICE_W-1:0] src_slice;
    logic [WORD_W-1:0]  word_sel;

    // Source selection over all frozen slices.
    always_comb begin
        src_slice = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (rd_src == SRC_W'(s)) begin
                src_slice = slices[s*SLICE_W +: SLICE_W];
            end
        end
    end

    // Part selection: part 0 is the top WORD_W bits.
    always_comb begin
        word_sel = '0;
        for (int p = 0; p < PARTS; p++) begin
            if (rd_part == PART_W'(p)) begin
                word_sel = src_slice[(PARTS-1-p)*WORD_W +: WORD_W];
            end
        end
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data  <= '0;
            out_valid <= 1'b0;
            out_last  <= 1'b0;
        end else begin
            out_data  <= word_sel;
            out_valid <= rd_en;
            out_last  <= rd_en && rd_last;
        end
    end

    p_last_marks_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);
    p_valid_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> out_valid);
    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !out_valid);
endmodule

// File: rtl/l1a_readout_buf.sv
// Module: top of the level-1 accept readout buffer.
// One double-banked slice ring per source, a shared drain controller and a
// word multiplexer. Assumes SLICE_W is a whole multiple of WORD_W.
module l1a_readout_buf #(
    parameter int NUM_SRC = xrb_pkg::NUM_SRC_D,
    parameter int NUM_CELL = xrb_pkg::NUM_CELL_D,
    parameter int NUM_SLC = xrb_pkg::NUM_SLC_D,
    parameter int SLICE_W = xrb_pkg::SLICE_W_D,
    parameter int WORD_W = xrb_pkg::WORD_W_D,
    parameter int QDEPTH = xrb_pkg::QDEPTH_D
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SRC-1:0]         src_valid,
    input  logic [NUM_SRC*SLICE_W-1:0] src_data,
    input  logic                       l1a,
    output logic [WORD_W-1:0]          out_data,
    output logic                       out_valid,
    output logic                       out_last,
    output logic                       overflow
);
    localparam int SLOTS  = NUM_CELL * NUM_SLC;
    localparam int PARTS  = SLICE_W / WORD_W;
    localparam int SRC_W  = $clog2(NUM_SRC);
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int PART_W = (PARTS > 1) ? $clog2(PARTS) : 1;

    logic                       rd_en, rd_last, live_bank, swap;
    logic [SRC_W-1:0]           rd_src;
    logic [SLOT_W-1:0]          rd_slot;
    logic [PART_W-1:0]          rd_part;
    logic [NUM_SRC*SLICE_W-1:0] ring_rd;

    xrb_readout_ctrl #(
        .NUM_SRC(NUM_SRC), .SLOTS(SLOTS), .PARTS(PARTS), .QDEPTH(QDEPTH)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .l1a(l1a),
        .rd_en(rd_en), .rd_last(rd_last), .rd_src(rd_src), .rd_slot(rd_slot),
        .rd_part(rd_part), .live_bank(live_bank), .swap(swap), .overflow(overflow)
    );

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_ring
        xrb_slice_ring #(.SLICE_W(SLICE_W), .SLOTS(SLOTS)) u_ring (
            .clk(clk), .rst_n(rst_n),
            .wr_en(src_valid[s]), .wr_data(src_data[s*SLICE_W +: SLICE_W]),
            .live_bank(live_bank), .swap(swap), .rd_slot(rd_slot),
            .rd_data(ring_rd[s*SLICE_W +: SLICE_W])
        );
    end

    xrb_word_mux #(.NUM_SRC(NUM_SRC), .SLICE_W(SLICE_W), .WORD_W(WORD_W)) u_mux (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_last(rd_last),
        .rd_src(rd_src), .rd_part(rd_part), .slices(ring_rd),
        .out_data(out_data), .out_valid(out_valid), .out_last(out_last)
    );
endmodule

// File: tb/l1a_readout_buf_test.sv
module l1a_readout_buf_test;
    localparam int NS = 5;
    localparam int SW = 32;
    localparam int EVW = 240;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src_valid = '0;
    logic [NS*SW-1:0] src_data = '0;
    logic          l1a = 1'b0;
    logic [15:0]   out_data;
    logic          out_valid, out_last, overflow;
    int            n_run = 0;
    int            n_fail = 0;
    bit            done = 1'b0;

    // Fill table: {seed, valid writes per source, gap mode}
    localparam int unsigned VEC [4][3] = '{
        '{32'h11, 24, 0},
        '{32'h22, 37, 0},
        '{32'h33, 50, 1},
        '{32'h44, 72, 0}
    };

    always #2 clk = ~clk;

    l1a_readout_buf uut (
        .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_data(src_data),
        .l1a(l1a), .out_data(out_data), .out_valid(out_valid),
        .out_last(out_last), .overflow(overflow)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int seed, input int s, input int k);
        return {seed[7:0], s[7:0], k[15:0]};
    endfunction

    // Word w of an event filled with n valid writes per source (R2, R3).
    function automatic logic [15:0] exp_word(input int seed, input int n, input int w);
        int s = w / 48;
        int slot = (w % 48) / 2;
        int k = slot + 24 * ((n - 1 - slot) / 24);
        logic [31:0] v = mk(seed, s, k);
        return (w % 2 == 0) ? v[31:16] : v[15:0];
    endfunction

    task automatic write_all(input int seed, input int n, input bit gap);
        int k = 0;
        bit skip = 1'b0;
        while (k < n) begin
            @(negedge clk);
            if (gap && skip) begin
                src_valid = '0;
                src_data = {NS{32'hDEAD_BEEF}};
            end else begin
                src_valid = '1;
                for (int s = 0; s < NS; s++) src_data[s*SW +: SW] = mk(seed, s, k);
                k++;
            end
            skip = gap ? !skip : 1'b0;
        end
        @(negedge clk);
        src_valid = '0;
        src_data = '0;
    endtask

    task automatic pulse_accept();
        @(negedge clk) l1a = 1'b1;
        @(negedge clk) l1a = 1'b0;
        chk(out_valid == 1'b0, "R5 no word in cycle after accept", 32'(out_valid), 0);
    endtask

    task automatic collect(input int seed, input int n, input bit cmp, input string tag);
        for (int w = 0; w < EVW; w++) begin
            @(negedge clk);
            chk(out_valid == 1'b1, (w == 0) ? "R5 first word present" : "R3 valid stream", 32'(out_valid), 1);
            chk(out_last == (w == EVW - 1), "R4 end marker position", 32'(out_last), 32'(w == EVW - 1));
            if (cmp) chk(out_data == exp_word(seed, n, w), tag, 32'(out_data), 32'(exp_word(seed, n, w)));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R3: run did not finish, actual 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R9 reset out_valid", 32'(out_valid), 0);
        chk(out_last == 1'b0, "R9 reset out_last", 32'(out_last), 0);
        chk(overflow == 1'b0, "R9 reset overflow", 32'(overflow), 0);
        rst_n = 1'b1;

        // Table: fills with wrap and valid gaps (R1, R2, R3)
        for (int i = 0; i < 4; i++) begin
            write_all(int'(VEC[i][0]), int'(VEC[i][1]), VEC[i][2] != 0);
            pulse_accept();
            collect(int'(VEC[i][0]), int'(VEC[i][1]), 1'b1, "R1 R2 R3 event word");
            @(negedge clk);
            chk(out_valid == 1'b0, "R3 idle after event", 32'(out_valid), 0);
        end

        // R6: writes during drain land in the other bank
        write_all(32'h51, 24, 1'b0);
        pulse_accept();
        fork
            collect(32'h51, 24, 1'b1, "R6 frozen event untouched");
            write_all(32'h62, 24, 1'b0);
        join
        pulse_accept();
        collect(32'h62, 24, 1'b1, "R6 next event from other bank");

        // R7/R8: three accepts during a drain
        repeat (3) @(negedge clk);
        pulse_accept();
        fork
            begin
                collect(0, 24, 1'b0, "R7");
                collect(0, 24, 1'b0, "R7");
                collect(0, 24, 1'b0, "R7");
            end
            begin
                repeat (5) @(negedge clk);
                for (int p = 0; p < 2; p++) begin
                    @(negedge clk) l1a = 1'b1;
                    @(negedge clk) l1a = 1'b0;
                end
                chk(overflow == 1'b0, "R7 two held accepts no overflow", 32'(overflow), 0);
                @(negedge clk) l1a = 1'b1;
                @(negedge clk) l1a = 1'b0;
                chk(overflow == 1'b1, "R8 third accept overflows", 32'(overflow), 1);
            end
        join
        @(negedge clk);
        chk(out_valid == 1'b0, "R7 idle after queue drained", 32'(out_valid), 0);
        chk(overflow == 1'b1, "R8 overflow sticky", 32'(overflow), 1);

        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(overflow == 1'b0, "R9 reset clears overflow", 32'(overflow), 0);
        chk(out_valid == 1'b0, "R9 idle after reset", 32'(out_valid), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule